// File: doc/BRIEF.md
# Staged Power Enable Controller

This block turns four configuration words and three control pins into a vector of power enables, one bit per circuit section of a radio front end. A mode pin picks either the receive word or the transmit word. That mode word is then masked by two staging words, and each staging word takes effect only while its own stage pin is high. Software can therefore load a "warm-up" staging word holding the oscillator and PLL sections and a "full" staging word holding the whole signal path. Power sequencing is then done with pins alone: stage 1 first, then stage 2 once the loops have settled. With both stage pins low, the part is asleep and every enable is off.

The words are loaded over a three-wire serial link made up of a shift clock, a data line and a latch line. A frame is a 24-bit data word followed by a 3-bit address, most significant bit first, shifted while the latch line is low. The rising edge of latch commits the word. A fifth address holds an override word. When the override is armed, register-held values replace the three pins, so the whole power sequence can be driven from the serial link alone. A readback port exposes every word for test. The enable vector is registered on the system clock, so it cannot glitch.

Top module: `pse_ctrl`

## Requirements
- R1: After reset, all five words read back as 0 and every bit of `pwr_en` is 0.
- R2: A serial frame shifts 27 bits MSB first while `ser_lat` is low: data bits 23..0, then address bits 2..0. Each bit is taken on a rising edge of `ser_clk`. A rising edge of `ser_lat` stores the data at the address: 0 receive word, 1 transmit word, 2 stage-1 word, 3 stage-2 word, 4 override word (low 4 bits). Afterwards the word reads back on `rd_data` when `rd_addr` selects it.
- R3: Bit 23 is unused. It always reads back as 0 and `pwr_en[23]` is always 0, even when a frame writes it as 1.
- R4: When `pin_tx` is low the receive word is the mode word; when high the transmit word is.
- R5: With only stage pin 1 high, `pwr_en` equals mode word AND stage-1 word.
- R6: With only stage pin 2 high, `pwr_en` equals mode word AND stage-2 word.
- R7: With both stage pins high, `pwr_en` is the OR of the two masked results.
- R8: With both stage pins low, `pwr_en` is all zeros whatever the words hold (sleep).
- R9: `pwr_en` is registered: a pin change shows up after exactly one rising edge of `clk`, and not before it.
- R10: The override word holds bit 0 arm, bit 1 mode select, bit 2 stage 1 and bit 3 stage 2. While it is armed, these bits replace `pin_tx`, `pin_en1` and `pin_en2`, and the pins have no effect. Once it is disarmed, the pins rule again.
- R11: A frame addressed to 5, 6 or 7 changes no word. Reading those addresses returns 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_clk | input | 1 | Serial shift clock (asynchronous, synchronized inside) |
| ser_dat | input | 1 | Serial data, MSB first |
| ser_lat | input | 1 | Serial latch; low while shifting, rising edge commits |
| pin_tx | input | 1 | Mode select: 0 receive word, 1 transmit word |
| pin_en1 | input | 1 | Stage 1 enable pin |
| pin_en2 | input | 1 | Stage 2 enable pin |
| rd_addr | input | 3 | Readback address |
| rd_data | output | 24 | Readback data of the addressed word |
| pwr_en | output | 24 | Registered per-section power enables |

## Verification
The bench drives the sleep case with fully populated words, where a design that skipped the sleep gating would power sections. It also drives each single-stage case, where swapping the two staging words or using AND instead of OR for the dual stage gives wrong masks. It writes all ones to catch bit 23 being stored or passed to the output. It frames unused addresses to catch decoders that alias them onto the real words. The override is armed with pin values opposite to the override bits, so a design that still listened to the pins would show a different mask. The output is sampled just before and just after the first clock edge following a pin change, which catches a combinational path or an extra stage of delay.

// File: rtl/pse_pkg.sv
package pse_pkg;
  localparam int PSE_DATA_W     = 24;
  localparam int PSE_ADDR_W     = 3;
  localparam int PSE_UNUSED_BIT = 23;

  // word addresses
  localparam int ADR_RX   = 0;
  localparam int ADR_TX   = 1;
  localparam int ADR_STG1 = 2;
  localparam int ADR_STG2 = 3;
  localparam int ADR_OVR  = 4;

  // override word fields
  localparam int OVR_W    = 4;
  localparam int OVR_ARM  = 0;
  localparam int OVR_TX   = 1;
  localparam int OVR_EN1  = 2;
  localparam int OVR_EN2  = 3;
endpackage

// File: rtl/pse_sync.sv
module pse_sync #(
  parameter int STAGES = 2,
  parameter bit RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= {STAGES{RST_VAL}};
    else        chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/pse_serial_rx.sv
module pse_serial_rx #(
  parameter int DATA_W = 24,
  parameter int ADDR_W = 3,
  parameter int SYNC_N = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ser_clk,
  input  logic              ser_dat,
  input  logic              ser_lat,
  output logic              wr_stb,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data
);
  localparam int FRAME_W = DATA_W + ADDR_W;

  logic sck_s, sdt_s, slt_s;
  logic sck_d, slt_d;
  logic sck_rise, lat_rise, shift_en;
  logic [FRAME_W-1:0] sh_q;

  pse_sync #(.STAGES(SYNC_N), .RST_VAL(1'b0)) u_sck (.clk(clk), .rst_n(rst_n), .d(ser_clk), .q(sck_s));
  pse_sync #(.STAGES(SYNC_N), .RST_VAL(1'b0)) u_sdt (.clk(clk), .rst_n(rst_n), .d(ser_dat), .q(sdt_s));
  pse_sync #(.STAGES(SYNC_N), .RST_VAL(1'b1)) u_slt (.clk(clk), .rst_n(rst_n), .d(ser_lat), .q(slt_s));

  assign sck_rise = sck_s & ~sck_d;
  assign lat_rise = slt_s & ~slt_d;
  assign shift_en = sck_rise & ~slt_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_d   <= 1'b0;
      slt_d   <= 1'b1;
      sh_q    <= '0;
      wr_stb  <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
    end else begin
      sck_d  <= sck_s;
      slt_d  <= slt_s;
      if (shift_en) sh_q <= {sh_q[FRAME_W-2:0], sdt_s};
      wr_stb <= lat_rise;
      if (lat_rise) begin
        wr_addr <= sh_q[ADDR_W-1:0];
        wr_data <= sh_q[FRAME_W-1:ADDR_W];
      end
    end
  end
endmodule

// File: rtl/pse_regfile.sv
module pse_regfile #(
  parameter int DATA_W     = 24,
  parameter int ADDR_W     = 3,
  parameter int UNUSED_BIT = 23
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_stb,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic [DATA_W-1:0] rx_q,
  output logic [DATA_W-1:0] tx_q,
  output logic [DATA_W-1:0] stg1_q,
  output logic [DATA_W-1:0] stg2_q,
  output logic [pse_pkg::OVR_W-1:0] ovr_q
);
  import pse_pkg::*;
  localparam int NWORDS = 4;
  localparam logic [DATA_W-1:0] KEEP = ~(DATA_W'(1) << UNUSED_BIT);

  logic [DATA_W-1:0] words_q [NWORDS];

  for (genvar g = 0; g < NWORDS; g++) begin : g_word
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) words_q[g] <= '0;
      else if (wr_stb && wr_addr == ADDR_W'(g)) words_q[g] <= wr_data & KEEP;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ovr_q <= '0;
    else if (wr_stb && wr_addr == ADDR_W'(ADR_OVR)) ovr_q <= wr_data[OVR_W-1:0];
  end

  assign rx_q   = words_q[ADR_RX];
  assign tx_q   = words_q[ADR_TX];
  assign stg1_q = words_q[ADR_STG1];
  assign stg2_q = words_q[ADR_STG2];

  always_comb begin
    rd_data = '0;
    if (rd_addr < ADDR_W'(NWORDS))            rd_data = words_q[rd_addr[1:0]];
    else if (rd_addr == ADDR_W'(ADR_OVR))     rd_data = DATA_W'(ovr_q);
  end
endmodule

// File: rtl/pse_enable_core.sv
module pse_enable_core #(
  parameter int DATA_W     = 24,
  parameter int UNUSED_BIT = 23
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pin_tx,
  input  logic              pin_en1,
  input  logic              pin_en2,
  input  logic [pse_pkg::OVR_W-1:0] ovr_q,
  input  logic [DATA_W-1:0] rx_q,
  input  logic [DATA_W-1:0] tx_q,
  input  logic [DATA_W-1:0] stg1_q,
  input  logic [DATA_W-1:0] stg2_q,
  output logic              eff_tx,
  output logic              eff_en1,
  output logic              eff_en2,
  output logic [DATA_W-1:0] pwr_en
);
  import pse_pkg::*;
  localparam logic [DATA_W-1:0] KEEP = ~(DATA_W'(1) << UNUSED_BIT);

  function automatic logic [DATA_W-1:0] stage_mask(
    input logic [DATA_W-1:0] mode, input logic [DATA_W-1:0] s1,
    input logic [DATA_W-1:0] s2,   input logic e1, input logic e2);
    return (((mode & s1) & {DATA_W{e1}}) | ((mode & s2) & {DATA_W{e2}})) & KEEP;
  endfunction

  logic [DATA_W-1:0] mode_w, en_next;

  assign eff_tx  = ovr_q[OVR_ARM] ? ovr_q[OVR_TX]  : pin_tx;
  assign eff_en1 = ovr_q[OVR_ARM] ? ovr_q[OVR_EN1] : pin_en1;
  assign eff_en2 = ovr_q[OVR_ARM] ? ovr_q[OVR_EN2] : pin_en2;
  assign mode_w  = eff_tx ? tx_q : rx_q;
  assign en_next = stage_mask(mode_w, stg1_q, stg2_q, eff_en1, eff_en2);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pwr_en <= '0;
    else        pwr_en <= en_next;
  end
endmodule

// File: rtl/pse_ctrl.sv
module pse_ctrl #(
  parameter int DATA_W     = pse_pkg::PSE_DATA_W,
  parameter int ADDR_W     = pse_pkg::PSE_ADDR_W,
  parameter int UNUSED_BIT = pse_pkg::PSE_UNUSED_BIT,
  parameter int SYNC_N     = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ser_clk,
  input  logic              ser_dat,
  input  logic              ser_lat,
  input  logic              pin_tx,
  input  logic              pin_en1,
  input  logic              pin_en2,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic [DATA_W-1:0] pwr_en
);
  logic              wr_stb;
  logic [ADDR_W-1:0] wr_addr;
  logic [DATA_W-1:0] wr_data;
  logic [DATA_W-1:0] rx_q, tx_q, stg1_q, stg2_q;
  logic [pse_pkg::OVR_W-1:0] ovr_q;
  logic eff_tx, eff_en1, eff_en2;

  pse_serial_rx #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .SYNC_N(SYNC_N)) u_rx (
    .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_dat(ser_dat), .ser_lat(ser_lat),
    .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data));

  pse_regfile #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .UNUSED_BIT(UNUSED_BIT)) u_rf (
    .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .rx_q(rx_q), .tx_q(tx_q),
    .stg1_q(stg1_q), .stg2_q(stg2_q), .ovr_q(ovr_q));

  pse_enable_core #(.DATA_W(DATA_W), .UNUSED_BIT(UNUSED_BIT)) u_core (
    .clk(clk), .rst_n(rst_n), .pin_tx(pin_tx), .pin_en1(pin_en1), .pin_en2(pin_en2),
    .ovr_q(ovr_q), .rx_q(rx_q), .tx_q(tx_q), .stg1_q(stg1_q), .stg2_q(stg2_q),
    .eff_tx(eff_tx), .eff_en1(eff_en1), .eff_en2(eff_en2), .pwr_en(pwr_en));
endmodule

// File: rtl/pse_ctrl_chk.sv
module pse_ctrl_chk #(
  parameter int DATA_W     = 24,
  parameter int ADDR_W     = 3,
  parameter int UNUSED_BIT = 23
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_stb,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [DATA_W-1:0] wr_data,
  input logic [DATA_W-1:0] rx_q,
  input logic [DATA_W-1:0] tx_q,
  input logic [DATA_W-1:0] stg1_q,
  input logic [DATA_W-1:0] stg2_q,
  input logic              eff_tx,
  input logic              eff_en1,
  input logic              eff_en2,
  input logic [DATA_W-1:0] pwr_en
);
  localparam logic [DATA_W-1:0] KEEP = ~(DATA_W'(1) << UNUSED_BIT);

  // R8: sleep forces all enables off on the next edge
  p_sleep_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!eff_en1 && !eff_en2) |=> (pwr_en == '0));

  // R3: unused bit never driven
  p_unused_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_en[UNUSED_BIT] == 1'b0));

  // R2: commit to receive word stores the frame data
  p_commit_rx_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && wr_addr == ADDR_W'(0)) |=> (rx_q == ($past(wr_data) & KEEP)));

  // R11: without a commit the mode words hold
  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_stb |=> ($stable(rx_q) && $stable(tx_q) && $stable(stg1_q) && $stable(stg2_q)));

  // R5/R4: stage 1 only, transmit mode
  p_stage1_tx_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (eff_en1 && !eff_en2 && eff_tx) |=> (pwr_en == ($past(tx_q & stg1_q) & KEEP)));

  // R6/R4: stage 2 only, receive mode
  p_stage2_rx_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!eff_en1 && eff_en2 && !eff_tx) |=> (pwr_en == ($past(rx_q & stg2_q) & KEEP)));
endmodule

bind pse_ctrl pse_ctrl_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .UNUSED_BIT(UNUSED_BIT)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data),
  .rx_q(rx_q), .tx_q(tx_q), .stg1_q(stg1_q), .stg2_q(stg2_q),
  .eff_tx(eff_tx), .eff_en1(eff_en1), .eff_en2(eff_en2), .pwr_en(pwr_en));

// File: tb/tb_pse_ctrl.sv
`timescale 1ns/1ps
module tb_pse_ctrl;
  localparam int DW = 24;
  localparam int AW = 3;
  localparam logic [DW-1:0] KEEP = 24'h7F_FFFF;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ser_clk = 1'b0, ser_dat = 1'b0, ser_lat = 1'b1;
  logic pin_tx = 1'b0, pin_en1 = 1'b0, pin_en2 = 1'b0;
  logic [AW-1:0] rd_addr = '0;
  logic [DW-1:0] rd_data, pwr_en;

  int vecs = 0, miss = 0;
  logic [DW-1:0] m_rx = '0, m_tx = '0, m_s1 = '0, m_s2 = '0;

  always #10 clk = ~clk;

  pse_ctrl dut (.clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_dat(ser_dat),
    .ser_lat(ser_lat), .pin_tx(pin_tx), .pin_en1(pin_en1), .pin_en2(pin_en2),
    .rd_addr(rd_addr), .rd_data(rd_data), .pwr_en(pwr_en));

  function automatic logic [DW-1:0] model(input logic tx, input logic e1, input logic e2);
    logic [DW-1:0] md, r;
    md = tx ? m_tx : m_rx;
    r = '0;
    if (e1) r = r | (md & m_s1);
    if (e2) r = r | (md & m_s2);
    return r & KEEP;
  endfunction

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    vecs++;
    if (act !== exp) begin
      miss++;
      $display("FAIL %s: got %06h expected %06h", req, act, exp);
    end
  endtask

  task automatic send_frame(input logic [AW-1:0] a, input logic [DW-1:0] d);
    logic [DW+AW-1:0] f;
    f = {d, a};
    @(negedge clk) ser_lat = 1'b0;
    repeat (4) @(negedge clk);
    for (int i = DW+AW-1; i >= 0; i--) begin
      ser_dat = f[i];
      repeat (4) @(negedge clk);
      ser_clk = 1'b1;
      repeat (4) @(negedge clk);
      ser_clk = 1'b0;
    end
    repeat (4) @(negedge clk);
    ser_lat = 1'b1;
    repeat (8) @(negedge clk);
  endtask

  task automatic read_chk(input string req, input logic [AW-1:0] a, input logic [DW-1:0] exp);
    @(negedge clk) rd_addr = a;
    #1 check(req, rd_data, exp);
  endtask

  task automatic pins_chk(input string req, input logic tx, input logic e1, input logic e2);
    @(negedge clk) begin pin_tx = tx; pin_en1 = e1; pin_en2 = e2; end
    @(negedge clk) check(req, pwr_en, model(tx, e1, e2));
  endtask

  task automatic t_reset;
    for (int a = 0; a < 5; a++) read_chk("R1 reset word", AW'(a), '0);
    check("R1 reset pwr_en", pwr_en, '0);
  endtask

  task automatic t_write;
    send_frame(3'd0, 24'h5A_C3E1); m_rx = 24'h5A_C3E1;
    send_frame(3'd1, 24'h3C_0F96); m_tx = 24'h3C_0F96;
    send_frame(3'd2, 24'h0F_00FF); m_s1 = 24'h0F_00FF;
    read_chk("R2 rx word", 3'd0, m_rx);
    read_chk("R2 tx word", 3'd1, m_tx);
    read_chk("R2 stage1 word", 3'd2, m_s1);
  endtask

  task automatic t_unused;
    send_frame(3'd3, 24'hFF_FFFF); m_s2 = 24'hFF_FFFF & KEEP;
    read_chk("R3 bit23 readback", 3'd3, 24'h7F_FFFF);
    send_frame(3'd0, 24'hFF_FFFF); m_rx = KEEP;
    pins_chk("R3 bit23 output", 1'b0, 1'b0, 1'b1);
    check("R3 bit23 low", {23'd0, pwr_en[23]}, '0);
    send_frame(3'd0, 24'h5A_C3E1); m_rx = 24'h5A_C3E1;
  endtask

  task automatic t_modes;
    pins_chk("R5 stage1 rx (R4)", 1'b0, 1'b1, 1'b0);
    pins_chk("R5 stage1 tx (R4)", 1'b1, 1'b1, 1'b0);
    pins_chk("R6 stage2 rx", 1'b0, 1'b0, 1'b1);
    pins_chk("R6 stage2 tx", 1'b1, 1'b0, 1'b1);
    pins_chk("R7 both rx", 1'b0, 1'b1, 1'b1);
    pins_chk("R7 both tx", 1'b1, 1'b1, 1'b1);
    pins_chk("R8 sleep rx", 1'b0, 1'b0, 1'b0);
    pins_chk("R8 sleep tx", 1'b1, 1'b0, 1'b0);
  endtask

  task automatic t_latency;
    pins_chk("R9 prior", 1'b1, 1'b1, 1'b0);
    @(negedge clk) begin pin_tx = 1'b0; pin_en2 = 1'b1; end
    #2 check("R9 before edge", pwr_en, model(1'b1, 1'b1, 1'b0));
    @(negedge clk) check("R9 after edge", pwr_en, model(1'b0, 1'b1, 1'b1));
  endtask

  task automatic t_override;
    @(negedge clk) begin pin_tx = 1'b1; pin_en1 = 1'b0; pin_en2 = 1'b1; end
    send_frame(3'd4, 24'h00_0005);
    read_chk("R10 override readback", 3'd4, 24'h00_0005);
    check("R10 armed rx stage1", pwr_en, model(1'b0, 1'b1, 1'b0));
    @(negedge clk) begin pin_tx = 1'b0; pin_en1 = 1'b1; pin_en2 = 1'b0; end
    @(negedge clk) check("R10 pins ignored", pwr_en, model(1'b0, 1'b1, 1'b0));
    send_frame(3'd4, 24'h00_000B);
    check("R10 armed tx stage2", pwr_en, model(1'b1, 1'b0, 1'b1));
    send_frame(3'd4, 24'h00_0000);
    check("R10 disarmed pins rule", pwr_en, model(1'b0, 1'b1, 1'b0));
  endtask

  task automatic t_ignored;
    send_frame(3'd5, 24'hFF_FFFF);
    send_frame(3'd6, 24'h12_3456);
    send_frame(3'd7, 24'hAB_CDEF);
    read_chk("R11 rx kept", 3'd0, m_rx);
    read_chk("R11 tx kept", 3'd1, m_tx);
    read_chk("R11 stage1 kept", 3'd2, m_s1);
    read_chk("R11 stage2 kept", 3'd3, m_s2);
    read_chk("R11 override kept", 3'd4, '0);
    read_chk("R11 addr5 reads 0", 3'd5, '0);
    read_chk("R11 addr7 reads 0", 3'd7, '0);
  endtask

  initial begin
    #(200000 * 20);
    miss++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, miss);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset;
    t_write;
    t_unused;
    t_modes;
    t_latency;
    t_override;
    t_ignored;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, miss);
    $finish;
  end
endmodule